// File: doc/BRIEF.md
# Double-Pumped Request Link

This block moves a bus request made of two packets across a shared bus within a single bus clock cycle. The send half takes packet A and packet B on a request handshake. It drives an active-low start-of-request line for the first fast cycle of the next bus cycle. It then drives an active-low address strobe, made of parallel lines that carry one waveform. Packet A sits on the packet lines while the strobe falls, and packet B sits there while it rises.

The receive half watches the start line, the strobe lines and the packet lines. It takes packet A on a strobe falling edge that follows a start-of-request, and packet B on the next rising edge. It then presents both packets together with a one-cycle valid pulse at the following bus clock boundary.

Everything runs on one fast clock that is `RATIO` times the bus clock; `RATIO` must be a multiple of 4. A free-running phase counter marks the bus cycle. Phase 0 is the first fast cycle of a bus cycle.

Top module: `dp_req_link`

## Requirements
- R1: While rst_ni is low and in the first cycle after it, start_n_o is 1, every strb_n_o line is 1, pkt_o is 0, and rx_valid_o and rx_err_o are 0.
- R2: req_ready_o is 1 for exactly one fast cycle in every RATIO, the last phase of the bus cycle. A request is taken only when req_valid_i and req_ready_o are both 1, and it is launched in the bus cycle that follows.
- R3: start_n_o is 0 only in phase 0 of a launched bus cycle and is 1 in all other cycles. Bus cycles with no request leave it at 1.
- R4: In a launched bus cycle, every strb_n_o line is 0 in phases RATIO/4 to 3*RATIO/4-1 and 1 otherwise. The low time is therefore half a bus cycle, and all lines are identical.
- R5: pkt_o carries packet A in phases 0 to RATIO/2-1 of a launched bus cycle and packet B in the rest of it. pkt_o is 0 in bus cycles with no request.
- R6: The receiver treats the strobe as high only when all of its lines are high. On a falling edge that follows a start-of-request, it stores rx_pkt_i as packet A. On the next rising edge it stores rx_pkt_i as packet B and pulses rx_valid_o for one cycle in the following cycle, with rx_req_o = {A, B} (A in the upper half).
- R7: A strobe falling edge with no start-of-request seen since the last packet A capture stores nothing.
- R8: A strobe rising edge with no stored packet A pulses rx_err_o for one cycle in the following cycle. rx_valid_o stays 0 in that case.
- R9: Requests taken in consecutive bus cycles are each launched and each delivered once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | fast clock, RATIO times the bus clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| req_valid_i | input | 1 | request offered |
| pkt_a_i | input | W | first packet of the request |
| pkt_b_i | input | W | second packet of the request |
| req_ready_o | output | 1 | request taken this cycle if valid |
| start_n_o | output | 1 | start-of-request, active low |
| strb_n_o | output | LINES | address strobe lines, active low |
| pkt_o | output | W | packet lines to the bus |
| rx_start_n_i | input | 1 | received start-of-request |
| rx_strb_n_i | input | LINES | received strobe lines |
| rx_pkt_i | input | W | received packet lines |
| rx_valid_o | output | 1 | one-cycle pulse, rx_req_o valid |
| rx_req_o | output | 2*W | {packet A, packet B} |
| rx_err_o | output | 1 | rising strobe edge without packet A |

## Verification
In one fast cycle, the valid pulse for request n can coincide with the start-of-request and packet A of request n+1 at phase 0. The bench provokes this by looping the send half back to the receive half and offering requests in most bus cycles, drawn at random. In each such phase 0 it checks the delivered {A, B} of the previous request and the new launch outputs, each against the bench's own model. A further directed sequence drives a falling edge with no start-of-request and then a rising edge, and expects an error pulse with no valid pulse.

// File: rtl/dp_req_pkg.sv
package dp_req_pkg;
  localparam int STRB_LINES = 2;
  typedef enum logic [1:0] {EDGE_NONE, EDGE_FALL, EDGE_RISE} strb_edge_e;
endpackage

// File: rtl/dp_phase_cnt.sv
module dp_phase_cnt #(
  parameter int RATIO = 4,
  localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [PW-1:0] phase_o
);
  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               phase_o <= '0;
    else if (phase_o == LAST)  phase_o <= '0;
    else                       phase_o <= phase_o + 1'b1;
  end

  // R2
  phase_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == LAST |=> phase_o == '0);
endmodule

// File: rtl/dp_req_tx.sv
module dp_req_tx #(
  parameter int W     = 16,
  parameter int RATIO = 4,
  parameter int LINES = dp_req_pkg::STRB_LINES,
  localparam int PW   = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PW-1:0]    phase_i,
  input  logic             req_valid_i,
  input  logic [W-1:0]     pkt_a_i,
  input  logic [W-1:0]     pkt_b_i,
  output logic             req_ready_o,
  output logic             start_n_o,
  output logic [LINES-1:0] strb_n_o,
  output logic [W-1:0]     pkt_o
);
  localparam logic [PW-1:0] LAST    = PW'(RATIO - 1);
  localparam logic [PW-1:0] FALL_PH = PW'(RATIO / 4);
  localparam logic [PW-1:0] RISE_PH = PW'(3 * RATIO / 4);
  localparam logic [PW-1:0] MID_PH  = PW'(RATIO / 2);
  localparam int            HALF    = RATIO / 2;

  logic         active_q;
  logic [W-1:0] a_q, b_q;
  logic         strb_low;

  assign req_ready_o = (phase_i == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      a_q      <= '0;
      b_q      <= '0;
    end else if (req_ready_o) begin
      active_q <= req_valid_i;
      if (req_valid_i) begin
        a_q <= pkt_a_i;
        b_q <= pkt_b_i;
      end
    end
  end

  assign start_n_o = !(active_q && phase_i == '0);
  assign strb_low  = active_q && phase_i >= FALL_PH && phase_i < RISE_PH;
  assign pkt_o     = !active_q ? '0 : (phase_i < MID_PH) ? a_q : b_q;

  // one driver per strobe line, all on the same waveform
  for (genvar l = 0; l < LINES; l++) begin : g_strb
    assign strb_n_o[l] = !strb_low;
  end

  logic [PW:0] low_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              low_cnt_q <= '0;
    else if (strb_n_o != '1)  low_cnt_q <= low_cnt_q + 1'b1;
    else                      low_cnt_q <= '0;
  end

  // R4
  strb_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_n_o != '1 |-> low_cnt_q < (PW+1)'(HALF));
  // R4
  strb_follows_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_n_o |-> strb_n_o == '1);
  // R3
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_n_o |=> start_n_o);
endmodule

// File: rtl/dp_req_rx.sv
module dp_req_rx #(
  parameter int W     = 16,
  parameter int LINES = dp_req_pkg::STRB_LINES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_start_n_i,
  input  logic [LINES-1:0] rx_strb_n_i,
  input  logic [W-1:0]     rx_pkt_i,
  output logic             rx_valid_o,
  output logic [2*W-1:0]   rx_req_o,
  output logic             rx_err_o
);
  import dp_req_pkg::*;

  logic         strb_hi, prev_q, armed_q, have_a_q;
  logic [W-1:0] a_q;
  strb_edge_e   edge_e;

  assign strb_hi = &rx_strb_n_i;

  always_comb begin
    edge_e = EDGE_NONE;
    if (prev_q && !strb_hi)      edge_e = EDGE_FALL;
    else if (!prev_q && strb_hi) edge_e = EDGE_RISE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= 1'b1;
      armed_q    <= 1'b0;
      have_a_q   <= 1'b0;
      a_q        <= '0;
      rx_req_o   <= '0;
      rx_valid_o <= 1'b0;
      rx_err_o   <= 1'b0;
    end else begin
      prev_q     <= strb_hi;
      rx_valid_o <= 1'b0;
      rx_err_o   <= 1'b0;
      if (!rx_start_n_i) armed_q <= 1'b1;
      unique case (edge_e)
        EDGE_FALL: if (armed_q) begin
          a_q      <= rx_pkt_i;
          have_a_q <= 1'b1;
          armed_q  <= 1'b0;
        end
        EDGE_RISE: if (have_a_q) begin
          rx_req_o   <= {a_q, rx_pkt_i};
          rx_valid_o <= 1'b1;
          have_a_q   <= 1'b0;
        end else begin
          rx_err_o <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R8
  valid_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> !rx_err_o);
  // R6
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  // R6
  valid_after_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(strb_hi) && !$past(prev_q));
endmodule

// File: rtl/dp_req_link.sv
module dp_req_link #(
  parameter int W     = 16,
  parameter int RATIO = 4,
  parameter int LINES = dp_req_pkg::STRB_LINES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [W-1:0]     pkt_a_i,
  input  logic [W-1:0]     pkt_b_i,
  output logic             req_ready_o,
  output logic             start_n_o,
  output logic [LINES-1:0] strb_n_o,
  output logic [W-1:0]     pkt_o,
  input  logic             rx_start_n_i,
  input  logic [LINES-1:0] rx_strb_n_i,
  input  logic [W-1:0]     rx_pkt_i,
  output logic             rx_valid_o,
  output logic [2*W-1:0]   rx_req_o,
  output logic             rx_err_o
);
  localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1;

  logic [PW-1:0] phase;

  dp_phase_cnt #(.RATIO(RATIO)) i_phase (
    .clk_i, .rst_ni, .phase_o(phase)
  );

  dp_req_tx #(.W(W), .RATIO(RATIO), .LINES(LINES)) i_tx (
    .clk_i, .rst_ni, .phase_i(phase), .req_valid_i, .pkt_a_i, .pkt_b_i,
    .req_ready_o, .start_n_o, .strb_n_o, .pkt_o
  );

  dp_req_rx #(.W(W), .LINES(LINES)) i_rx (
    .clk_i, .rst_ni, .rx_start_n_i, .rx_strb_n_i, .rx_pkt_i,
    .rx_valid_o, .rx_req_o, .rx_err_o
  );
endmodule

// File: tb/test_dp_req_link.sv
module test_dp_req_link;
  localparam int W = 16, RATIO = 4, LINES = 2;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_ni = 0;
  logic req_valid = 0;
  logic [W-1:0] pkt_a = '0, pkt_b = '0;
  logic req_ready, start_n, rx_valid, rx_err;
  logic [LINES-1:0] strb_n;
  logic [W-1:0] pkt;
  logic [2*W-1:0] rx_req;
  logic inj = 0, inj_start_n = 1;
  logic [LINES-1:0] inj_strb_n = '1;
  logic [W-1:0] inj_pkt = '0;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_req_link #(.W(W), .RATIO(RATIO), .LINES(LINES)) i_dp_req_link (
    .clk_i(clk), .rst_ni, .req_valid_i(req_valid), .pkt_a_i(pkt_a), .pkt_b_i(pkt_b),
    .req_ready_o(req_ready), .start_n_o(start_n), .strb_n_o(strb_n), .pkt_o(pkt),
    .rx_start_n_i(inj ? inj_start_n : start_n),
    .rx_strb_n_i(inj ? inj_strb_n : strb_n),
    .rx_pkt_i(inj ? inj_pkt : pkt),
    .rx_valid_o(rx_valid), .rx_req_o(rx_req), .rx_err_o(rx_err)
  );

  function automatic logic exp_start(int ph, logic v);
    return !(v && ph == 0);
  endfunction
  function automatic logic [LINES-1:0] exp_strb(int ph, logic v);
    return (v && ph >= RATIO/4 && ph < 3*RATIO/4) ? '0 : '1;
  endfunction
  function automatic logic [W-1:0] exp_pkt(int ph, logic v, logic [W-1:0] a, logic [W-1:0] b);
    return !v ? '0 : (ph < RATIO/2) ? a : b;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic prev_v = 0;
  logic [2*W-1:0] prev_ab = '0;

  // at negedge of last phase: offer request, then check one bus cycle
  task automatic bus_cycle(logic v, logic [W-1:0] a, logic [W-1:0] b);
    req_valid = v; pkt_a = a; pkt_b = b;
    for (int ph = 0; ph < RATIO; ph++) begin
      @(negedge clk);
      if (ph == 0) begin
        req_valid = 0;
        chk("R6/R9 valid", 64'(rx_valid), 64'(prev_v));
        if (prev_v) chk("R6/R9 data", 64'(rx_req), 64'(prev_ab));
        chk("R8 no err", 64'(rx_err), 64'(0));
      end else begin
        chk("R6 pulse", 64'(rx_valid), 64'(0));
      end
      chk("R2 ready", 64'(req_ready), 64'(ph == RATIO-1));
      chk("R3 start", 64'(start_n), 64'(exp_start(ph, v)));
      chk("R4 strobe", 64'(strb_n), 64'(exp_strb(ph, v)));
      chk("R5 packet", 64'(pkt), 64'(exp_pkt(ph, v, a, b)));
    end
    prev_v = v; prev_ab = {a, b};
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned dummy;
    dummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    // R1 in reset
    chk("R1 start", 64'(start_n), 64'(1));
    chk("R1 strobe", 64'(strb_n), 64'(2'b11));
    chk("R1 packet", 64'(pkt), 64'(0));
    chk("R1 valid", 64'(rx_valid), 64'(0));
    chk("R1 err", 64'(rx_err), 64'(0));
    rst_ni = 1;
    @(negedge clk);
    chk("R1 start after", 64'(start_n), 64'(1));
    chk("R1 strobe after", 64'(strb_n), 64'(2'b11));
    while (!req_ready) @(negedge clk);

    // directed corners: back-to-back, all-ones/zeros packets
    bus_cycle(1, 16'hFFFF, 16'h0000);
    bus_cycle(1, 16'h0000, 16'hFFFF);
    bus_cycle(1, 16'hA5A5, 16'hA5A5);
    bus_cycle(0, '0, '0);
    // R9 random mix, mostly consecutive requests
    for (int i = 0; i < 400; i++)
      bus_cycle(($urandom % 4) != 0, W'($urandom), W'($urandom));
    bus_cycle(0, '0, '0);
    bus_cycle(0, '0, '0);

    // R7/R8: fall with no start is ignored, so the rise has no packet A
    inj = 1;
    @(negedge clk); inj_pkt = 16'h1111; inj_strb_n = '0;
    @(negedge clk); inj_strb_n = '1;
    @(negedge clk);
    chk("R7/R8 err", 64'(rx_err), 64'(1));
    chk("R8 no valid", 64'(rx_valid), 64'(0));
    @(negedge clk);
    chk("R8 err pulse", 64'(rx_err), 64'(0));

    // R6: one line low counts as strobe low
    inj_start_n = 0; inj_pkt = 16'h1234;
    @(negedge clk); inj_start_n = 1; inj_strb_n = 2'b10;
    @(negedge clk); inj_pkt = 16'h5678;
    @(negedge clk); inj_strb_n = '1;
    @(negedge clk);
    chk("R6 direct valid", 64'(rx_valid), 64'(1));
    chk("R6 direct data", 64'(rx_req), 64'(32'h1234_5678));
    chk("R6 direct no err", 64'(rx_err), 64'(0));
    @(negedge clk);
    chk("R6 direct pulse", 64'(rx_valid), 64'(0));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule